// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor load/store port and a slower memory. It holds recently read memory blocks in a two-way set-associative array. Each set carries one bit that names the way used least recently. The processor issues byte or 2-byte reads and writes. A read that hits is answered from the array without touching memory. A read that misses fetches the whole aligned block over a block-wide memory port, installs it and answers from the fetched block.

Writes go through to memory every time. A write that hits also patches the cached bytes. A write that misses leaves the array alone, so lines are never filled by writes and no line is ever dirty. There is no write buffer: the processor is held until memory acknowledges each write.

The processor raises `cpu_req` and holds the request fields steady until `cpu_done` pulses for one cycle. It then drops `cpu_req` for at least one cycle. The memory side sees `mem_req` and its fields held steady until it returns `mem_ack` for one cycle. The set count and block size are parameters. The default is 8-bit addresses, 2 sets and 2-byte blocks. An access never crosses a block, so a 2-byte access uses an even offset when blocks are 2 bytes.

Top module: `wtc_cache`

## Requirements
- R1: An address is split, from the low end, into a byte offset of log2(BLOCK_BYTES) bits, a set index of log2(SETS) bits and a tag made of the remaining bits. In the default configuration address 0x13 selects set 1 with tag 0x4 and offset 1, and its block fetch uses address 0x12.
- R2: After reset every line is invalid, `cpu_done` and `mem_req` are low, and the first read of any address is a miss.
- R3: A read hit pulses `cpu_done` in the cycle after the request is accepted and issues no memory request.
- R4: A read miss issues exactly one memory read (`mem_we`=0) at the block-aligned address. It installs the returned block and returns the requested bytes from it.
- R5: On a read miss an invalid way is filled first, with way 0 before way 1. When both ways are valid, the way named by the set's LRU bit is replaced.
- R6: Every read hit, write hit and refill makes the other way of that set the least recently used.
- R7: Every write, hit or miss, issues exactly one memory write (`mem_we`=1) carrying the byte address, the size and the data, and no memory read. `cpu_done` follows only after `mem_ack`.
- R8: A write hit also updates the cached bytes, so a later read hit returns the written value.
- R9: A write miss neither installs a block nor changes the LRU bit, so a later read of that address misses.
- R10: A byte access uses data bits [7:0] and a read returns the byte zero-extended. A 2-byte access is little-endian: the lower address holds bits [7:0] and the next address holds bits [15:8].
- R11: While `mem_req` is high without `mem_ack`, the request stays high and its address, direction, size and data do not change.
- R12: `cpu_done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_half | input | 1 | 1 = 2-byte access, 0 = byte access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 16 | Write data, little-endian |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` on a read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write-through, 0 = block fetch |
| mem_half | output | 1 | Size of a write-through |
| mem_addr | output | ADDR_W | Byte address (write) or block-aligned address (fetch) |
| mem_wdata | output | 16 | Write-through data |
| mem_rdata | input | BLOCK_BYTES*8 | Fetched block, lowest address in bits [7:0] |
| mem_ack | input | 1 | One-cycle acknowledge of the memory request |

## Verification
The hardest situation to reach is a victim choice that depends on history. This happens when both ways of a set are valid and the LRU bit was last moved by a write hit rather than a read. It also happens when a write miss sits between two reads and must leave that bit alone. A directed sequence fills both ways of set 1 and touches one way by a write hit. It then brings in a third tag and checks which older tag still hits. A long pseudo-random run spreads sixteen tags over the two sets with mixed sizes and directions to produce the same situations many times. In both parts the bench's behavioural cache model predicts each hit, miss and fetch address, and the memory model predicts each returned value.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/wtc_rst_sync.sv
module wtc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
  import wtc_pkg::*;
#(
  parameter int unsigned SETS  = 2,
  parameter int unsigned TAG_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic [WAYS-1:0]          hit_vec,
  output logic [WAYS-1:0]          vld_vec,
  input  logic                     fill_en,
  input  logic                     fill_way,
  input  logic [$clog2(SETS)-1:0]  fill_set,
  input  logic [TAG_W-1:0]         fill_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  valid_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_this;

    assign wr_this = fill_en && (int'(fill_way) == w);

    always_comb begin
      valid_d = valid_q;
      if (wr_this) valid_d[fill_set] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (wr_this) tag_q[fill_set] <= fill_tag;
    end

    assign vld_vec[w] = valid_q[lk_set];
    assign hit_vec[w] = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store
  import wtc_pkg::*;
#(
  parameter int unsigned SETS        = 2,
  parameter int unsigned BLOCK_BYTES = 2
) (
  input  logic                                     clk,
  input  logic [$clog2(SETS)-1:0]                  rd_set,
  output logic [WAYS-1:0][BLOCK_BYTES*8-1:0]       rd_blk,
  input  logic                                     fill_en,
  input  logic                                     fill_way,
  input  logic [$clog2(SETS)-1:0]                  fill_set,
  input  logic [BLOCK_BYTES*8-1:0]                 fill_blk,
  input  logic                                     upd_en,
  input  logic                                     upd_way,
  input  logic [$clog2(SETS)-1:0]                  upd_set,
  input  logic [$clog2(BLOCK_BYTES)-1:0]           upd_off,
  input  logic                                     upd_half,
  input  logic [15:0]                              upd_data
);
  localparam int unsigned BLK_W = BLOCK_BYTES * 8;

  logic [BLOCK_BYTES-1:0] byte_en;
  logic [7:0]             byte_val [BLOCK_BYTES];

  always_comb begin
    for (int b = 0; b < BLOCK_BYTES; b++) begin
      byte_en[b]  = (b == int'(upd_off)) || (upd_half && (b == int'(upd_off) + 1));
      byte_val[b] = (b == int'(upd_off)) ? upd_data[7:0] : upd_data[15:8];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [BLK_W-1:0] blk_q [SETS];
    logic             fill_this;
    logic             upd_this;

    assign fill_this = fill_en && (int'(fill_way) == w);
    assign upd_this  = upd_en  && (int'(upd_way)  == w);

    always_ff @(posedge clk) begin
      for (int b = 0; b < BLOCK_BYTES; b++) begin
        if (fill_this) begin
          blk_q[fill_set][b*8 +: 8] <= fill_blk[b*8 +: 8];
        end else if (upd_this && byte_en[b]) begin
          blk_q[upd_set][b*8 +: 8] <= byte_val[b];
        end
      end
    end

    assign rd_blk[w] = blk_q[rd_set];
  end
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
  parameter int unsigned SETS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic                    lru_way,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic                    touch_way
);
  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (touch_en) lru_d[touch_set] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign lru_way = lru_q[rd_set];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic        hit_any,
  input  logic        mem_ack,
  output ctrl_state_e state_q
);
  ctrl_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (we)           state_d = ST_STORE;
          else if (hit_any) state_d = ST_DONE;
          else              state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_ack) state_d = ST_DONE;
      ST_STORE: if (mem_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SETS        = 2,
  parameter int unsigned BLOCK_BYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic                     cpu_half,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [15:0]              cpu_wdata,
  output logic                     cpu_done,
  output logic [15:0]              cpu_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic                     mem_half,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [15:0]              mem_wdata,
  input  logic [BLOCK_BYTES*8-1:0] mem_rdata,
  input  logic                     mem_ack
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int unsigned BLK_W = BLOCK_BYTES * 8;

  logic                        rst_sync_n;
  ctrl_state_e                 state;
  logic [SET_W-1:0]            set_f;
  logic [TAG_W-1:0]            tag_f;
  logic [OFF_W-1:0]            off_f;
  logic [WAYS-1:0]             hit_vec;
  logic [WAYS-1:0]             vld_vec;
  logic                        hit_any;
  logic                        hit_way;
  logic                        lru_way;
  logic                        victim_way;
  logic                        in_idle;
  logic                        accept;
  logic                        fill_en;
  logic                        upd_en;
  logic                        touch_en;
  logic                        touch_way;
  logic [WAYS-1:0][BLK_W-1:0]  rd_blk;
  logic [15:0]                 rdata_q;
  logic [15:0]                 rdata_d;
  logic                        rdata_en;

  function automatic logic [15:0] pick_bytes(input logic [BLK_W-1:0] blk,
                                             input logic [OFF_W-1:0] off,
                                             input logic half);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = 8'h00;
    hi = 8'h00;
    for (int b = 0; b < BLOCK_BYTES; b++) begin
      if (b == int'(off))     lo = blk[b*8 +: 8];
      if (b == int'(off) + 1) hi = blk[b*8 +: 8];
    end
    return half ? {hi, lo} : {8'h00, lo};
  endfunction

  wtc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign off_f = cpu_addr[OFF_W-1:0];
  assign set_f = cpu_addr[OFF_W +: SET_W];
  assign tag_f = cpu_addr[ADDR_W-1 -: TAG_W];

  wtc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_set   (set_f),
    .lk_tag   (tag_f),
    .hit_vec  (hit_vec),
    .vld_vec  (vld_vec),
    .fill_en  (fill_en),
    .fill_way (victim_way),
    .fill_set (set_f),
    .fill_tag (tag_f)
  );

  wtc_data_store #(.SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES)) u_data (
    .clk      (clk),
    .rd_set   (set_f),
    .rd_blk   (rd_blk),
    .fill_en  (fill_en),
    .fill_way (victim_way),
    .fill_set (set_f),
    .fill_blk (mem_rdata),
    .upd_en   (upd_en),
    .upd_way  (hit_way),
    .upd_set  (set_f),
    .upd_off  (off_f),
    .upd_half (cpu_half),
    .upd_data (cpu_wdata)
  );

  wtc_lru #(.SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_set    (set_f),
    .lru_way   (lru_way),
    .touch_en  (touch_en),
    .touch_set (set_f),
    .touch_way (touch_way)
  );

  wtc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (cpu_req),
    .we      (cpu_we),
    .hit_any (hit_any),
    .mem_ack (mem_ack),
    .state_q (state)
  );

  assign hit_any = |hit_vec;
  assign hit_way = hit_vec[1];

  always_comb begin
    if (!vld_vec[0])      victim_way = 1'b0;
    else if (!vld_vec[1]) victim_way = 1'b1;
    else                  victim_way = lru_way;
  end

  assign in_idle   = (state == ST_IDLE);
  assign accept    = in_idle && cpu_req;
  assign fill_en   = (state == ST_FETCH) && mem_ack;
  assign upd_en    = accept && cpu_we && hit_any;
  assign touch_en  = (accept && hit_any) || fill_en;
  assign touch_way = fill_en ? victim_way : hit_way;

  assign mem_req   = (state == ST_FETCH) || (state == ST_STORE);
  assign mem_we    = (state == ST_STORE);
  assign mem_half  = cpu_half;
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (state == ST_FETCH) ? {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                                         : cpu_addr;

  always_comb begin
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (accept && !cpu_we && hit_any) begin
      rdata_en = 1'b1;
      rdata_d  = pick_bytes(rd_blk[hit_way], off_f, cpu_half);
    end else if (fill_en) begin
      rdata_en = 1'b1;
      rdata_d  = pick_bytes(mem_rdata, off_f, cpu_half);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_rdata = rdata_q;
  assign cpu_done  = (state == ST_DONE);
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_done,
  input logic              in_idle,
  input logic [1:0]        hit_vec,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic              mem_half,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata
);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_half) && $stable(mem_wdata)));

  p_ack_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> cpu_done);

  p_hit_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && !cpu_we && (|hit_vec)) |=> (cpu_done && !mem_req));

  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && !cpu_we && !(|hit_vec)) |=> (mem_req && !mem_we));

  p_write_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && cpu_we) |=> (mem_req && mem_we));

  p_single_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_done  (cpu_done),
  .in_idle   (in_idle),
  .hit_vec   (hit_vec),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_half  (mem_half),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_wtc_cache.sv
`timescale 1ns/1ps
module test_wtc_cache;
  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic        cpu_we;
  logic        cpu_half;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        mem_req;
  logic        mem_we;
  logic        mem_half;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;

  int total;
  int bad;

  // memory model and its activity log
  logic [7:0]  mem [256];
  int          n_rd;
  int          n_wr;
  logic [7:0]  last_rd_addr;
  logic [7:0]  last_wr_addr;
  logic        last_wr_half;
  logic [15:0] last_wr_data;

  // behavioural cache model: [way][set]
  bit          mv [2][2];
  logic [5:0]  mt [2][2];
  bit          ml [2];

  wtc_cache i_wtc_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_half(cpu_half), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // memory responder, driven on the falling edge
  initial begin
    int          wait_cnt;
    bit          pend;
    logic [7:0]  hold_addr;
    logic        hold_we;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    wait_cnt  = 0;
    pend      = 0;
    hold_addr = '0;
    hold_we   = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!pend) begin
          pend      = 1;
          hold_addr = mem_addr;
          hold_we   = mem_we;
          wait_cnt  = (n_rd + n_wr) % 3;
        end
        if (wait_cnt == 0) begin
          chk(mem_addr == hold_addr && mem_we == hold_we, "R11 request held steady",
              {mem_we, mem_addr}, {hold_we, hold_addr});
          if (mem_we) begin
            mem[mem_addr] = mem_wdata[7:0];
            if (mem_half) mem[8'(mem_addr + 1)] = mem_wdata[15:8];
            last_wr_addr = mem_addr;
            last_wr_half = mem_half;
            last_wr_data = mem_wdata;
            n_wr++;
          end else begin
            mem_rdata    = {mem[8'(mem_addr + 1)], mem[mem_addr]};
            last_rd_addr = mem_addr;
            n_rd++;
          end
          mem_ack = 1'b1;
          pend    = 0;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic do_acc(input bit we, input bit half, input logic [7:0] a,
                        input logic [15:0] wd, input string lbl);
    int          rd0;
    int          wr0;
    int          cyc;
    int          s;
    logic [5:0]  tg;
    bit          hit;
    int          hw;
    int          vic;
    logic [15:0] exp_d;
    logic [15:0] got;
    s   = int'(a[1]);
    tg  = a[7:2];
    hit = 0;
    hw  = 0;
    for (int w = 0; w < 2; w++) if (mv[w][s] && mt[w][s] == tg) begin hit = 1; hw = w; end
    rd0 = n_rd;
    wr0 = n_wr;
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_half  = half;
    cpu_addr  = a;
    cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 100);
    chk(cyc < 100, {lbl, " R12 access completes"}, cyc, 0);
    got     = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    chk(!cpu_done, {lbl, " R12 done lasts one cycle"}, cpu_done, 0);
    if (!we) begin
      exp_d = half ? {mem[8'(a + 1)], mem[a]} : {8'h00, mem[a]};
      chk(got == exp_d, {lbl, " R10 R8 read data"}, got, exp_d);
      if (hit) begin
        chk(n_rd == rd0, {lbl, " R3 R6 hit needs no fetch"}, n_rd - rd0, 0);
        chk(cyc == 1, {lbl, " R3 hit latency"}, cyc, 1);
        ml[s] = (hw == 0);
      end else begin
        chk(n_rd == rd0 + 1, {lbl, " R4 R5 R2 miss fetches once"}, n_rd - rd0, 1);
        chk(last_rd_addr == {a[7:1], 1'b0}, {lbl, " R1 R4 fetch address"}, last_rd_addr, {a[7:1], 1'b0});
        if (!mv[0][s])      vic = 0;
        else if (!mv[1][s]) vic = 1;
        else                vic = ml[s] ? 1 : 0;
        mv[vic][s] = 1;
        mt[vic][s] = tg;
        ml[s]      = (vic == 0);
      end
    end else begin
      chk(n_wr == wr0 + 1 && n_rd == rd0, {lbl, " R7 one write-through"}, n_wr - wr0, 1);
      chk(last_wr_addr == a && last_wr_half == half && last_wr_data == wd,
          {lbl, " R7 write-through fields"}, {7'd0, last_wr_half, last_wr_addr, last_wr_data},
          {7'd0, half, a, wd});
      if (hit) ml[s] = (hw == 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lfsr;
    total = 0; bad = 0; n_rd = 0; n_wr = 0;
    last_rd_addr = '0; last_wr_addr = '0; last_wr_half = 1'b0; last_wr_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int w = 0; w < 2; w++) for (int s = 0; s < 2; s++) begin mv[w][s] = 0; mt[w][s] = '0; end
    ml[0] = 0; ml[1] = 0;
    cpu_req = 0; cpu_we = 0; cpu_half = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!cpu_done && !mem_req, "R2 outputs idle in reset", {cpu_done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cpu_done && !mem_req, "R2 outputs idle after reset", {cpu_done, mem_req}, 0);

    do_acc(0, 0, 8'h13, 16'h0, "R1 R2 first read 0x13 misses, set 1 tag 4");
    do_acc(0, 0, 8'h33, 16'h0, "R5 invalid way filled");
    do_acc(0, 0, 8'h12, 16'h0, "R3 hit on 0x12");
    do_acc(0, 0, 8'h53, 16'h0, "R5 LRU victim is 0x33");
    do_acc(0, 0, 8'h13, 16'h0, "R6 0x13 survived");
    do_acc(0, 0, 8'h33, 16'h0, "R6 0x33 was evicted");
    do_acc(1, 0, 8'h20, 16'h0077, "R9 write miss");
    do_acc(0, 0, 8'h20, 16'h0, "R9 write miss did not allocate");
    do_acc(1, 0, 8'h13, 16'h00A5, "R8 byte write hit");
    do_acc(0, 0, 8'h13, 16'h0, "R8 read back written byte");
    do_acc(0, 1, 8'h12, 16'h0, "R10 little-endian 2-byte read");
    do_acc(1, 1, 8'h32, 16'hBEEF, "R8 2-byte write hit");
    do_acc(0, 1, 8'h32, 16'h0, "R10 read back 2-byte write");
    do_acc(1, 0, 8'h73, 16'h0011, "R9 write miss keeps LRU");
    do_acc(0, 0, 8'h93, 16'h0, "R6 R9 victim after write miss");
    do_acc(0, 0, 8'h33, 16'h0, "R6 check survivor");

    lfsr = 32'h1ACE5;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      bit         wr;
      bit         hf;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 32'h0);
      a  = {2'b00, lfsr[5:0]};
      wr = (lfsr[9:8] == 2'b00);
      hf = lfsr[12];
      if (hf) a[0] = 1'b0;
      do_acc(wr, hf, a, lfsr[31:16], "R4 R5 R6 R7 random mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule